// File: doc/BRIEF.md
# Test-and-Modify Bit Mask Sequencer

This block sequences two read-modify-write instructions that test an accumulator against a byte at an absolute 16-bit address and then modify that byte. When a start strobe arrives with a supported opcode, the unit fetches the two address bytes from the program stream, low byte first. It then reads the target byte and sets the negative and zero flags from the difference between the accumulator and that byte. After one more read of the same address, whose data is discarded, it writes the byte back. The written value has the accumulator's bits either set or cleared.

The unit drives a simple single-cycle memory bus: the read data must be valid in the same cycle as the address. It keeps its own copy of the program pointer. It signals every pointer advance on a strobe so the surrounding core can keep its PC in step. The carry, overflow and half-carry flags are outside this block and are never touched.

Top module: `tms_bitmask_seq`

## Requirements
- R1: After a synchronous active-low reset the unit is idle: busy, done, read strobe, write strobe, flag update, and both flag outputs are 0.
- R2: A start is accepted only while idle and only with opcode 0x0E (set bits) or 0x4E (clear bits). Any other opcode leaves the unit idle, with no bus read or write in the next cycle.
- R3: In the first step the unit reads the low address byte at the PC value sampled with the start. In the second step it reads the high address byte at that value plus one, wrapping from 0xFFFF to 0x0000. The PC-advance strobe is high in both steps.
- R4: The third step reads the byte at the address {high, low} assembled from the two fetched bytes.
- R5: At the end of the third step, N becomes bit 7 of (A minus the byte, modulo 256) and Z becomes 1 exactly when A equals the byte. The flag update strobe is high only in that step, and the flags hold their values in every other cycle.
- R6: The fourth step reads the same target address again without writing, and its data has no effect on the flags or on the written value.
- R7: For opcode 0x0E the fifth step writes (byte OR A) to the target address.
- R8: For opcode 0x4E the fifth step writes (byte AND NOT A) to the target address.
- R9: Done is high for exactly one cycle, the write step, and busy is high from the first step through the fifth. After that the unit is idle again.
- R10: A start strobe that arrives while the unit is busy, including in the write cycle, is ignored. The running sequence keeps its addresses, opcode and operand.
- R11: The accumulator and PC are sampled in the cycle the start is accepted. Later changes on those inputs do not affect the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe for the opcode on opcode_i |
| opcode_i | input | 8 | Instruction opcode, 0x0E or 0x4E accepted |
| acc_i | input | 8 | Accumulator value |
| pc_i | input | 16 | Program pointer at start |
| pc_inc_o | output | 1 | PC advanced by one this cycle |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read data, valid in the same cycle |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_upd_o | output | 1 | N and Z are loaded at the end of this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Write step, last cycle of the sequence |

## Verification
The write step, which also raises done, is the only cycle in which a new start strobe could collide with a finishing sequence. The bench provokes this by holding start high with the other opcode, a changed accumulator and a changed PC from the first fetch through the write cycle. It then checks that the unit goes idle right after the write and issues no fresh fetch. The written byte must still follow the original opcode and operand. The compare step and the redundant re-read are also checked apart from each other: the flags must already hold the compare result in the re-read cycle and must not move after it.

// File: rtl/tms_pkg.sv
// Shared types for the test-and-modify sequencer.
// Assumes 8-bit opcodes and a five-step sequence after the start cycle.
package tms_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADR_LO = 3'd1,
        ST_ADR_HI = 3'd2,
        ST_READ   = 3'd3,
        ST_REREAD = 3'd4,
        ST_WRITE  = 3'd5
    } tms_state_e;

    localparam logic [7:0] OPC_SETBITS = 8'h0E;
    localparam logic [7:0] OPC_CLRBITS = 8'h4E;
endpackage

// File: rtl/tms_ctrl.sv
// Step controller: accepts a start while idle for the two supported opcodes
// and walks the five bus steps. Assumes start_i is a level sampled per cycle.
module tms_ctrl
    import tms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] opcode_i,
    output tms_state_e state_o,
    output logic       accept_o,
    output logic       op_clr_o
);
    tms_state_e state_q;
    logic       clr_q;

    // Accept decision: idle and a known opcode.
    always_comb begin
        accept_o = (state_q == ST_IDLE) && start_i &&
                   ((opcode_i == OPC_SETBITS) || (opcode_i == OPC_CLRBITS));
    end

    // Step register and latched operation kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            clr_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE:   if (accept_o) begin
                               state_q <= ST_ADR_LO;
                               clr_q   <= (opcode_i == OPC_CLRBITS);
                           end
                ST_ADR_LO: state_q <= ST_ADR_HI;
                ST_ADR_HI: state_q <= ST_READ;
                ST_READ:   state_q <= ST_REREAD;
                ST_REREAD: state_q <= ST_WRITE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o  = state_q;
    assign op_clr_o = clr_q;
endmodule

// File: rtl/tms_addr.sv
// Address path: private program pointer plus the assembled target address.
// Assumes ADDR_W is exactly two data bytes, low byte fetched first.
module tms_addr
    import tms_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tms_state_e        state_i,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int unsigned HI_LSB = DATA_W;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] tgt_q;
    logic              fetch;

    assign fetch = (state_i == ST_ADR_LO) || (state_i == ST_ADR_HI);

    // Pointer load on accept and advance after each address-byte fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (accept_i) ptr_q <= pc_i;
        else if (fetch)    ptr_q <= ptr_q + ONE;
    end

    // Assemble the target address from the two fetched bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)                      tgt_q <= '0;
        else if (state_i == ST_ADR_LO)   tgt_q[HI_LSB-1:0] <= rdata_i;
        else if (state_i == ST_ADR_HI)   tgt_q[ADDR_W-1:HI_LSB] <= rdata_i[ADDR_W-HI_LSB-1:0];
    end

    // Bus address: pointer while fetching, target afterwards.
    assign addr_o = fetch ? ptr_q : tgt_q;
endmodule

// File: rtl/tms_alu.sv
// Compare and mask path: latches A at accept, captures the target byte on
// the first data read, derives N/Z from A minus byte, forms the write value.
module tms_alu
    import tms_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tms_state_e        state_i,
    input  logic              accept_i,
    input  logic              op_clr_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_upd_o
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] diff;
    logic              n_q, z_q;

    assign flag_upd_o = (state_i == ST_READ);
    assign diff       = acc_q - rdata_i;

    // Operand latch at accept.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (accept_i) acc_q <= acc_i;
    end

    // Target byte capture and flag load on the compare step only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            n_q    <= 1'b0;
            z_q    <= 1'b0;
        end else if (flag_upd_o) begin
            data_q <= rdata_i;
            n_q    <= diff[DATA_W-1];
            z_q    <= (diff == '0);
        end
    end

    // Write value: set or clear the bits selected by A.
    always_comb begin
        wdata_o = op_clr_i ? (data_q & ~acc_q) : (data_q | acc_q);
    end

    assign flag_n_o = n_q;
    assign flag_z_o = z_q;
endmodule

// File: rtl/tms_bitmask_seq.sv
// Top of the test-and-modify bit mask sequencer. Ties the controller,
// address path and compare/mask path to a single-cycle memory bus.
// Assumes read data is valid in the same cycle as the address.
module tms_bitmask_seq
    import tms_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              pc_inc_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_upd_o,
    output logic              busy_o,
    output logic              done_o
);
    tms_state_e state;
    logic       accept;
    logic       op_clr;

    tms_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .opcode_i (opcode_i),
        .state_o  (state),
        .accept_o (accept),
        .op_clr_o (op_clr)
    );

    tms_addr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (state),
        .accept_i (accept),
        .pc_i     (pc_i),
        .rdata_i  (mem_rdata_i),
        .addr_o   (mem_addr_o)
    );

    tms_alu #(.DATA_W(DATA_W)) u_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .accept_i   (accept),
        .op_clr_i   (op_clr),
        .acc_i      (acc_i),
        .rdata_i    (mem_rdata_i),
        .wdata_o    (mem_wdata_o),
        .flag_n_o   (flag_n_o),
        .flag_z_o   (flag_z_o),
        .flag_upd_o (flag_upd_o)
    );

    // Bus strobes decoded from the current step.
    always_comb begin
        pc_inc_o = (state == ST_ADR_LO) || (state == ST_ADR_HI);
        mem_rd_o = pc_inc_o || (state == ST_READ) || (state == ST_REREAD);
        mem_we_o = (state == ST_WRITE);
        done_o   = (state == ST_WRITE);
        busy_o   = (state != ST_IDLE);
    end
endmodule

// File: rtl/tms_chk.sv
// Protocol checker for the sequencer, bound to every instance of the top.
module tms_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pc_inc_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rd_o,
    input logic              mem_we_o,
    input logic              flag_n_o,
    input logic              flag_z_o,
    input logic              flag_upd_o,
    input logic              busy_o,
    input logic              done_o
);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_rd_o && !mem_we_o));
    // R3
    fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc_o |-> (mem_rd_o && !mem_we_o));
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_upd_o |=> ($stable(flag_n_o) && $stable(flag_z_o)));
    // R6
    reread_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> ($past(mem_rd_o) && !$past(pc_inc_o) && (mem_addr_o == $past(mem_addr_o))));
    // R9
    done_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mem_we_o && busy_o));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

bind tms_bitmask_seq tms_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_inc_o   (pc_inc_o),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_we_o   (mem_we_o),
    .flag_n_o   (flag_n_o),
    .flag_z_o   (flag_z_o),
    .flag_upd_o (flag_upd_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/tms_bitmask_seq_bench.sv
module tms_bitmask_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [7:0]  acc_i = 8'h00;
    logic [15:0] pc_i = 16'h0000;
    logic        pc_inc_o, mem_rd_o, mem_we_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_rdata_i, mem_wdata_o;
    logic        flag_n_o, flag_z_o, flag_upd_o, busy_o, done_o;

    int total = 0;
    int bad = 0;
    logic [7:0] mem [0:1023];

    always #4 clk = ~clk;

    assign mem_rdata_i = mem[mem_addr_o[9:0]];
    always @(posedge clk) if (mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;

    tms_bitmask_seq u_tms_bitmask_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .acc_i(acc_i), .pc_i(pc_i), .pc_inc_o(pc_inc_o), .mem_addr_o(mem_addr_o),
        .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i), .mem_wdata_o(mem_wdata_o),
        .mem_we_o(mem_we_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
        .flag_upd_o(flag_upd_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_wr(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d);
        return (op == 8'h4E) ? (d & ~a) : (d | a);
    endfunction

    function automatic logic exp_n(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] t;
        t = a - d;
        return t[7];
    endfunction

    // One full instruction; collide=1 holds a foreign start through the run.
    task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic [15:0] pc,
                          input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] d,
                          input logic collide);
        logic [15:0] pc1, tgt;
        logic [7:0]  wv;
        logic        en, ez;
        pc1 = pc + 16'd1;
        tgt = {hi, lo};
        wv  = exp_wr(op, a, d);
        en  = exp_n(a, d);
        ez  = (a == d);
        mem[pc[9:0]]  = lo;
        mem[pc1[9:0]] = hi;
        mem[tgt[9:0]] = d;
        opcode_i = op; acc_i = a; pc_i = pc; start_i = 1'b1;
        @(negedge clk);
        start_i = collide;
        opcode_i = (op == 8'h0E) ? 8'h4E : 8'h0E;
        acc_i = ~a;
        pc_i = pc ^ 16'h0040;
        chk("R3 lo addr", {16'h0, mem_addr_o}, {16'h0, pc});
        chk("R3 lo inc/rd", {pc_inc_o, mem_rd_o, busy_o}, 3'b111);
        @(negedge clk);
        chk("R3 hi addr", {16'h0, mem_addr_o}, {16'h0, pc1});
        chk("R3 hi inc/rd", {pc_inc_o, mem_rd_o}, 2'b11);
        @(negedge clk);
        chk("R4 target addr", {16'h0, mem_addr_o}, {16'h0, tgt});
        chk("R4 read/upd", {mem_rd_o, mem_we_o, pc_inc_o, flag_upd_o}, 4'b1001);
        @(negedge clk);
        chk("R6 reread addr", {16'h0, mem_addr_o}, {16'h0, tgt});
        chk("R6 reread strobes", {mem_rd_o, mem_we_o, flag_upd_o, done_o}, 4'b1000);
        chk("R5 flags N Z", {flag_n_o, flag_z_o}, {en, ez});
        @(negedge clk);
        chk("R9 done on write", {mem_we_o, done_o, busy_o}, 3'b111);
        chk("R7 R8 R11 wdata", {24'h0, mem_wdata_o}, {24'h0, wv});
        chk("R6 write addr", {16'h0, mem_addr_o}, {16'h0, tgt});
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 R9 idle after write", {busy_o, done_o, mem_rd_o, mem_we_o}, 4'b0000);
        chk("R7 R8 memory", {24'h0, mem[tgt[9:0]]}, {24'h0, wv});
        chk("R5 flags held", {flag_n_o, flag_z_o}, {en, ez});
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        r = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset", {busy_o, done_o, mem_rd_o, mem_we_o, flag_upd_o, flag_n_o, flag_z_o}, 7'b0);
        // R2 unsupported opcode ignored
        opcode_i = 8'h0C; start_i = 1'b1; pc_i = 16'h0120;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 bad opcode ignored", {busy_o, mem_rd_o, mem_we_o, pc_inc_o}, 4'b0000);
        // Directed corners
        run_op(8'h0E, 8'h5A, 16'h0130, 8'h10, 8'h12, 8'h5A, 1'b0); // R5 equal -> Z
        run_op(8'h4E, 8'h00, 16'h0140, 8'h20, 8'h06, 8'h01, 1'b0); // R5 0-1 -> N
        run_op(8'h0E, 8'h80, 16'h0150, 8'h30, 8'h0A, 8'h00, 1'b0); // R5 N from A bit
        run_op(8'h4E, 8'hFF, 16'h0160, 8'h40, 8'h0E, 8'hC3, 1'b0); // R8 all cleared
        run_op(8'h0E, 8'h00, 16'h0170, 8'h50, 8'h12, 8'h00, 1'b0); // R7 unchanged
        run_op(8'h0E, 8'h11, 16'hFFFF, 8'h60, 8'h16, 8'h82, 1'b0); // R3 pointer wrap
        run_op(8'h4E, 8'h0F, 16'h0180, 8'h70, 8'h1A, 8'hFF, 1'b1); // R10 collision
        run_op(8'h0E, 8'hF0, 16'h0190, 8'h80, 8'h1E, 8'h0F, 1'b1); // R10 collision
        // Constrained random mix
        for (int k = 0; k < 40; k++) begin
            logic [7:0]  op, a, lo, hi, d;
            logic [15:0] pc;
            r  = $urandom;
            op = r[0] ? 8'h4E : 8'h0E;
            a  = r[15:8];
            d  = r[23:16];
            if (r[1]) d = a;
            r  = $urandom;
            lo = r[7:0];
            hi = {r[13:8], 2'b10};
            pc = 16'h0100 + {8'h00, r[23:16] & 8'hEF};
            run_op(op, a, pc, lo, hi, d, r[24]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule